// File: doc/BRIEF.md
# Mixed-Page Translation Lookaside Buffer

This block is a small, fully associative address-translation cache. It holds recent translations from virtual page number to physical page number for a 48-bit virtual address space. Each slot carries a page-size tag. A small slot maps a 4 KB page and translates address bits 47..12. A huge slot maps a 2 MB page, translates only bits 47..21, and so covers the range of 512 small pages. A lookup is purely combinational: the virtual address goes in, and hit, physical address and page size come out in the same cycle. A miss tells the surrounding logic to start a page-table walk.

When a walk finishes, its result is installed through the fill port. Stale translations are removed in two ways. A targeted invalidate names a virtual page number and clears every slot whose range contains that page, whatever the slot's size. A full flush clears every slot in one cycle. Both are what a cross-core shootdown needs. The slot count is a parameter and defaults to 16. Replacement uses the lowest free slot first, then a round-robin pointer.

Top module: `tlb_mixed_page`

## Requirements
- R1: After reset every slot is empty. Every lookup reports a miss with `lk_pa_o` = 0 and `lk_huge_o` = 0.
- R2: A lookup that hits a small (4 KB, `fill_huge_i` = 0) slot returns, in the same cycle, `lk_hit_o` = 1, `lk_huge_o` = 0 and `lk_pa_o` = {stored PPN, `lk_va_i`[11:0]}.
- R3: A huge (2 MB, `fill_huge_i` = 1) slot hits any address whose bits 47..21 equal those of the filled page. It returns `lk_huge_o` = 1 and `lk_pa_o` = {stored PPN[27:9], `lk_va_i`[20:0]}. The low 9 PPN bits of a huge fill are ignored.
- R4: A lookup that no valid slot covers reports a miss, with `lk_pa_o` = 0 and `lk_huge_o` = 0.
- R5: A fill takes effect on the next clock edge. When no slot overlaps the fill and at least one slot is empty, the fill goes to the lowest-index empty slot.
- R6: When every slot is valid and none overlaps the fill, the victim is the slot named by a round-robin pointer. The pointer is 0 after reset and after a flush, and advances by one, wrapping, on each such fill.
- R7: Two pages overlap when they agree on bits 47..21, if either page is huge, or on bits 47..12 otherwise. A fill that overlaps existing slots overwrites the lowest-index overlapping slot and clears the other overlapping slots. At most one slot ever hits.
- R8: An invalidate (`inv_en_i`) clears, on the next edge, every slot whose range contains `inv_vpn_i`, both small and huge.
- R9: `flush_all_i` clears every slot in one cycle. A fill presented in the same cycle is dropped.
- R10: A lookup made while an invalidate covers the hitting slot, or while `flush_all_i` is high, reports a miss in that same cycle.
- R11: When an invalidate and a fill arrive in the same cycle, the invalidate applies to the old contents and the fill is still installed, even for the same page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lk_va_i | input | 48 | Virtual address to translate |
| lk_hit_o | output | 1 | A valid slot covers `lk_va_i` |
| lk_pa_o | output | 40 | Translated physical address, 0 on a miss |
| lk_huge_o | output | 1 | Hitting slot is a 2 MB page |
| fill_en_i | input | 1 | Install a translation this cycle |
| fill_vpn_i | input | 36 | Virtual page number (VA bits 47..12) of the fill |
| fill_ppn_i | input | 28 | Physical page number (PA bits 39..12) of the fill |
| fill_huge_i | input | 1 | Fill is a 2 MB mapping |
| inv_en_i | input | 1 | Invalidate the slots covering `inv_vpn_i` |
| inv_vpn_i | input | 36 | Virtual page number (VA bits 47..12) to invalidate |
| flush_all_i | input | 1 | Clear every slot |

## Verification
The embedded properties check, on every cycle, the rules that hold in every state:
- at most one slot hits;
- a miss drives zero outputs;
- the page offset passes straight through at the width of the hitting slot's size;
- a same-cycle invalidate or flush suppresses the hit;
- a fill writes exactly one slot, and that slot is free whenever a free slot exists and no slot overlaps;
- invalidated and flushed slots are empty one cycle later.

Only the bench's sequences can show which translation survives after a history of events, for example:
- round-robin eviction order once the buffer is full;
- a huge fill absorbing two small slots;
- refilling a slot freed by invalidation;
- a fill dropped under flush;
- a fill winning over a simultaneous invalidate of the same page.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

   // Address split shared by all slots.
   localparam int SMALL_OFF = 12;  // 4 KB page offset width
   localparam int HUGE_OFF  = 21;  // 2 MB page offset width

   typedef enum logic {
      PG_4K = 1'b0,
      PG_2M = 1'b1
   } pg_size_e;

endpackage

// File: rtl/tlb_slot.sv
module tlb_slot
   import tlb_pkg::*;
#(
   parameter int VPN_W  = 36,
   parameter int PPN_W  = 28,
   parameter int SPAN_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush_i,
   input  logic             wr_i,
   input  logic             clr_i,
   input  logic [VPN_W-1:0] fill_vpn_i,
   input  logic [PPN_W-1:0] fill_ppn_i,
   input  pg_size_e         fill_size_i,
   input  logic [VPN_W-1:0] lk_vpn_i,
   input  logic [VPN_W-1:0] inv_vpn_i,
   output logic             valid_o,
   output logic             lk_match_o,
   output logic             inv_cover_o,
   output logic             fill_ovl_o,
   output logic [PPN_W-1:0] ppn_o,
   output pg_size_e         size_o
);

   logic             valid_q;
   logic [VPN_W-1:0] vpn_q;
   logic [PPN_W-1:0] ppn_q;
   pg_size_e         size_q;

   // Compare either the full page number or only the 2 MB region bits.
   function automatic logic same_page(input logic [VPN_W-1:0] a,
                                      input logic [VPN_W-1:0] b,
                                      input logic             coarse);
      logic eq;
      if (coarse) eq = (a[VPN_W-1:SPAN_W] == b[VPN_W-1:SPAN_W]);
      else        eq = (a == b);
      return eq;
   endfunction

   always_comb begin
      lk_match_o  = valid_q && same_page(vpn_q, lk_vpn_i, size_q == PG_2M);
      inv_cover_o = valid_q && same_page(vpn_q, inv_vpn_i, size_q == PG_2M);
      fill_ovl_o  = valid_q && same_page(vpn_q, fill_vpn_i,
                                         (size_q == PG_2M) || (fill_size_i == PG_2M));
   end

   // Priority: flush, then write, then clear.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         vpn_q   <= '0;
         ppn_q   <= '0;
         size_q  <= PG_4K;
      end else if (flush_i) begin
         valid_q <= 1'b0;
      end else if (wr_i) begin
         valid_q <= 1'b1;
         vpn_q   <= fill_vpn_i;
         ppn_q   <= fill_ppn_i;
         size_q  <= fill_size_i;
      end else if (clr_i) begin
         valid_q <= 1'b0;
      end
   end

   assign valid_o = valid_q;
   assign ppn_o   = ppn_q;
   assign size_o  = size_q;

   p_clear_empties_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !wr_i) |=> !valid_q);

   p_flush_empties_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> !valid_q);

   p_write_fills_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && !flush_i) |=> (valid_q && size_q == $past(fill_size_i)));

endmodule

// File: rtl/tlb_alloc.sv
module tlb_alloc #(
   parameter int ENTRIES = 16,
   parameter int IDX_W   = $clog2(ENTRIES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               flush_i,
   input  logic               fill_i,
   input  logic [ENTRIES-1:0] valid_i,
   input  logic [ENTRIES-1:0] ovl_i,
   output logic [ENTRIES-1:0] wr_oh_o,
   output logic [ENTRIES-1:0] clr_dup_o
);

   localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

   logic [IDX_W-1:0] rr_q, rr_nxt;
   logic [IDX_W-1:0] first_ovl, first_free, pick;
   logic             any_ovl, any_free, go, advance;

   // Lowest index wins: scan from the top so the last assignment is lowest.
   always_comb begin
      first_ovl  = '0;
      first_free = '0;
      any_ovl    = 1'b0;
      any_free   = 1'b0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (ovl_i[i]) begin
            first_ovl = IDX_W'(i);
            any_ovl   = 1'b1;
         end
         if (!valid_i[i]) begin
            first_free = IDX_W'(i);
            any_free   = 1'b1;
         end
      end
   end

   assign go      = fill_i && !flush_i;
   assign pick    = any_ovl ? first_ovl : (any_free ? first_free : rr_q);
   assign advance = go && !any_ovl && !any_free;

   always_comb begin
      for (int i = 0; i < ENTRIES; i++) begin
         wr_oh_o[i] = go && (pick == IDX_W'(i));
      end
      clr_dup_o = go ? (ovl_i & ~wr_oh_o) : '0;
   end

   // Pointer wrap: free for a power-of-two count, explicit compare otherwise.
   generate
      if ((1 << IDX_W) == ENTRIES) begin : g_wrap_pow2
         assign rr_nxt = rr_q + 1'b1;
      end else begin : g_wrap_cmp
         assign rr_nxt = (rr_q == LAST) ? '0 : rr_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rr_q <= '0;
      else if (flush_i) rr_q <= '0;
      else if (advance) rr_q <= rr_nxt;
   end

   p_one_target_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      go |-> ($countones(wr_oh_o) == 1));

   p_free_first_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (go && !(&valid_i) && !(|ovl_i)) |-> ((wr_oh_o & valid_i) == '0));

   p_dup_only_ovl_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      ((clr_dup_o & ~ovl_i) == '0) && ((clr_dup_o & wr_oh_o) == '0));

   p_rr_hold_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (!flush_i && !(go && (&valid_i) && !(|ovl_i))) |=> $stable(rr_q));

endmodule

// File: rtl/tlb_mixed_page.sv
module tlb_mixed_page
   import tlb_pkg::*;
#(
   parameter int VA_W    = 48,
   parameter int PA_W    = 40,
   parameter int ENTRIES = 16
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [VA_W-1:0]           lk_va_i,
   output logic                      lk_hit_o,
   output logic [PA_W-1:0]           lk_pa_o,
   output logic                      lk_huge_o,
   input  logic                      fill_en_i,
   input  logic [VA_W-SMALL_OFF-1:0] fill_vpn_i,
   input  logic [PA_W-SMALL_OFF-1:0] fill_ppn_i,
   input  logic                      fill_huge_i,
   input  logic                      inv_en_i,
   input  logic [VA_W-SMALL_OFF-1:0] inv_vpn_i,
   input  logic                      flush_all_i
);

   localparam int VPN_W  = VA_W - SMALL_OFF;
   localparam int PPN_W  = PA_W - SMALL_OFF;
   localparam int SPAN_W = HUGE_OFF - SMALL_OFF;
   localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

   generate
      if (ENTRIES < 2) begin : g_chk_entries
         $error("tlb_mixed_page: ENTRIES must be at least 2");
      end
      if (VA_W <= HUGE_OFF || PA_W <= HUGE_OFF) begin : g_chk_widths
         $error("tlb_mixed_page: address widths must exceed the huge offset");
      end
   endgenerate

   logic [VPN_W-1:0]   lk_vpn;
   pg_size_e           fill_size;
   logic [ENTRIES-1:0] valid_v, match_v, cover_v, ovl_v;
   logic [ENTRIES-1:0] wr_v, dup_v, kill_v, clr_v, hit_v;
   logic [PPN_W-1:0]   ppn_a  [ENTRIES];
   pg_size_e           size_a [ENTRIES];

   assign lk_vpn    = lk_va_i[VA_W-1:SMALL_OFF];
   assign fill_size = fill_huge_i ? PG_2M : PG_4K;

   tlb_alloc #(
      .ENTRIES (ENTRIES),
      .IDX_W   (IDX_W)
   ) u_alloc (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush_i   (flush_all_i),
      .fill_i    (fill_en_i),
      .valid_i   (valid_v),
      .ovl_i     (ovl_v),
      .wr_oh_o   (wr_v),
      .clr_dup_o (dup_v)
   );

   generate
      for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
         assign kill_v[g] = inv_en_i && cover_v[g];
         assign clr_v[g]  = kill_v[g] || dup_v[g];
         assign hit_v[g]  = match_v[g] && !kill_v[g] && !flush_all_i;

         tlb_slot #(
            .VPN_W  (VPN_W),
            .PPN_W  (PPN_W),
            .SPAN_W (SPAN_W)
         ) u_slot (
            .clk         (clk),
            .rst_n       (rst_n),
            .flush_i     (flush_all_i),
            .wr_i        (wr_v[g]),
            .clr_i       (clr_v[g]),
            .fill_vpn_i  (fill_vpn_i),
            .fill_ppn_i  (fill_ppn_i),
            .fill_size_i (fill_size),
            .lk_vpn_i    (lk_vpn),
            .inv_vpn_i   (inv_vpn_i),
            .valid_o     (valid_v[g]),
            .lk_match_o  (match_v[g]),
            .inv_cover_o (cover_v[g]),
            .fill_ovl_o  (ovl_v[g]),
            .ppn_o       (ppn_a[g]),
            .size_o      (size_a[g])
         );
      end
   endgenerate

   // One-hot select of the hitting slot.
   logic [PPN_W-1:0] sel_ppn;
   logic             sel_huge;

   always_comb begin
      sel_ppn  = '0;
      sel_huge = 1'b0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (hit_v[i]) begin
            sel_ppn  = sel_ppn | ppn_a[i];
            sel_huge = sel_huge | (size_a[i] == PG_2M);
         end
      end
   end

   always_comb begin
      lk_hit_o  = |hit_v;
      lk_huge_o = lk_hit_o && sel_huge;
      if (!lk_hit_o)
         lk_pa_o = '0;
      else if (sel_huge)
         lk_pa_o = {sel_ppn[PPN_W-1:SPAN_W], lk_va_i[HUGE_OFF-1:0]};
      else
         lk_pa_o = {sel_ppn, lk_va_i[SMALL_OFF-1:0]};
   end

   p_single_hit_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_v));

   p_miss_zero_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      !lk_hit_o |-> (lk_pa_o == '0 && !lk_huge_o));

   p_small_offset_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      (lk_hit_o && !lk_huge_o) |-> (lk_pa_o[SMALL_OFF-1:0] == lk_va_i[SMALL_OFF-1:0]));

   p_huge_offset_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      (lk_hit_o && lk_huge_o) |-> (lk_pa_o[HUGE_OFF-1:0] == lk_va_i[HUGE_OFF-1:0]));

   p_inv_same_cycle_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      (inv_en_i && inv_vpn_i == lk_vpn) |-> !lk_hit_o);

   p_flush_same_cycle_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      flush_all_i |-> !lk_hit_o);

endmodule

// File: tb/tb_tlb_mixed_page.sv
module tb_tlb_mixed_page;

   typedef struct {
      logic        hit;
      logic [39:0] pa;
      logic        huge;
      int          req;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [47:0] lk_va = '0;
   logic        lk_hit;
   logic [39:0] lk_pa;
   logic        lk_huge;
   logic        fill_en = 1'b0;
   logic [35:0] fill_vpn = '0;
   logic [27:0] fill_ppn = '0;
   logic        fill_huge = 1'b0;
   logic        inv_en = 1'b0;
   logic [35:0] inv_vpn = '0;
   logic        flush_all = 1'b0;

   int   compared = 0;
   int   mismatched = 0;
   exp_t sb_q[$];
   event ev_sample;

   always #4 clk = ~clk;  // 125 MHz

   tlb_mixed_page dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .lk_va_i     (lk_va),
      .lk_hit_o    (lk_hit),
      .lk_pa_o     (lk_pa),
      .lk_huge_o   (lk_huge),
      .fill_en_i   (fill_en),
      .fill_vpn_i  (fill_vpn),
      .fill_ppn_i  (fill_ppn),
      .fill_huge_i (fill_huge),
      .inv_en_i    (inv_en),
      .inv_vpn_i   (inv_vpn),
      .flush_all_i (flush_all)
   );

   function automatic logic [39:0] model_pa(input logic [27:0] ppn,
                                            input logic [47:0] va,
                                            input logic        huge);
      return huge ? {ppn[27:9], va[20:0]} : {ppn, va[11:0]};
   endfunction

   // Driver side: push the expectation, then wake the monitor.
   task automatic expect_now(input logic hit, input logic [27:0] ppn,
                             input logic huge, input int req);
      exp_t e;
      #1;
      e.hit  = hit;
      e.pa   = hit ? model_pa(ppn, lk_va, huge) : 40'h0;
      e.huge = hit ? huge : 1'b0;
      e.req  = req;
      sb_q.push_back(e);
      -> ev_sample;
   endtask

   task automatic look(input logic [47:0] va, input logic hit,
                       input logic [27:0] ppn, input logic huge, input int req);
      @(negedge clk);
      lk_va = va;
      expect_now(hit, ppn, huge, req);
   endtask

   task automatic fill(input logic [47:0] va, input logic [27:0] ppn, input logic huge);
      @(negedge clk);
      fill_en   = 1'b1;
      fill_vpn  = va[47:12];
      fill_ppn  = ppn;
      fill_huge = huge;
      @(negedge clk);
      fill_en = 1'b0;
   endtask

   task automatic inval(input logic [47:0] va);
      @(negedge clk);
      inv_en  = 1'b1;
      inv_vpn = va[47:12];
      @(negedge clk);
      inv_en = 1'b0;
   endtask

   // Monitor: compare each expectation against the live outputs.
   initial begin
      forever begin
         @(ev_sample);
         while (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            compared++;
            if (lk_hit !== e.hit || lk_pa !== e.pa || lk_huge !== e.huge) begin
               mismatched++;
               $display("FAIL R%0d: got hit=%0b pa=%h huge=%0b, expected hit=%0b pa=%h huge=%0b",
                        e.req, lk_hit, lk_pa, lk_huge, e.hit, e.pa, e.huge);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      mismatched++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   localparam logic [47:0] VA_A = 48'h0000_1234_5000;
   localparam logic [47:0] VA_B = 48'h0000_1230_0000;
   localparam logic [47:0] VA_H = 48'h0000_4000_0000;
   localparam logic [47:0] VA_G = 48'h0000_1220_0000;
   localparam logic [47:0] VA_P = 48'h0000_0100_0000;

   initial begin
      // R1: reset state
      lk_va = VA_A;
      expect_now(1'b0, 28'h0, 1'b0, 1);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      look(48'h0, 1'b0, 28'h0, 1'b0, 1);                       // R1
      look(VA_A | 48'h123, 1'b0, 28'h0, 1'b0, 1);              // R1

      // R2 / R4: small page
      fill(VA_A, 28'h00A_BCDE, 1'b0);
      look(VA_A | 48'hABC, 1'b1, 28'h00A_BCDE, 1'b0, 2);       // R2
      look(VA_A | 48'hFFF, 1'b1, 28'h00A_BCDE, 1'b0, 2);       // R2
      look(VA_A + 48'h1000, 1'b0, 28'h0, 1'b0, 4);             // R4

      // R3 / R4: huge page with nonzero low PPN bits (ignored)
      fill(VA_H, 28'h012_3455, 1'b1);
      look(VA_H | 48'h1F_F123, 1'b1, 28'h012_3455, 1'b1, 3);   // R3
      look(VA_H, 1'b1, 28'h012_3455, 1'b1, 3);                 // R3
      look(VA_H + 48'h20_0000, 1'b0, 28'h0, 1'b0, 4);          // R4
      look(VA_H - 48'h1, 1'b0, 28'h0, 1'b0, 4);                // R4

      // R7: refill of the same small page overwrites
      fill(VA_B, 28'h000_0111, 1'b0);
      look(VA_B | 48'h10, 1'b1, 28'h000_0111, 1'b0, 2);        // R2
      fill(VA_A, 28'h00F_FFFF, 1'b0);
      look(VA_A | 48'h5, 1'b1, 28'h00F_FFFF, 1'b0, 7);         // R7

      // R7: huge fill absorbs both small pages in its region
      fill(VA_G, 28'h077_7000, 1'b1);
      look(VA_A | 48'hABC, 1'b1, 28'h077_7000, 1'b1, 7);       // R7
      look(VA_B | 48'h10, 1'b1, 28'h077_7000, 1'b1, 7);        // R7
      look(VA_H | 48'h42, 1'b1, 28'h012_3455, 1'b1, 7);        // R7 untouched

      // R8: invalidate a page inside the huge region
      inval(VA_B);
      look(VA_A | 48'hABC, 1'b0, 28'h0, 1'b0, 8);              // R8
      look(VA_B, 1'b0, 28'h0, 1'b0, 8);                        // R8
      look(VA_H | 48'h42, 1'b1, 28'h012_3455, 1'b1, 8);        // R8 other kept

      // R10: lookup during invalidate of the same region
      @(negedge clk);
      inv_en  = 1'b1;
      inv_vpn = VA_H[47:12];
      lk_va   = VA_H | 48'h1_2345;
      expect_now(1'b0, 28'h0, 1'b0, 10);                       // R10
      @(negedge clk);
      inv_en = 1'b0;
      expect_now(1'b0, 28'h0, 1'b0, 8);                        // R8

      // R9 / R10: flush
      fill(VA_H, 28'h012_3400, 1'b1);
      look(VA_H | 48'h7, 1'b1, 28'h012_3400, 1'b1, 3);         // R3
      @(negedge clk);
      flush_all = 1'b1;
      lk_va     = VA_H | 48'h7;
      expect_now(1'b0, 28'h0, 1'b0, 10);                       // R10
      @(negedge clk);
      flush_all = 1'b0;
      expect_now(1'b0, 28'h0, 1'b0, 9);                        // R9
      @(negedge clk);
      flush_all = 1'b1;
      fill_en   = 1'b1;
      fill_vpn  = VA_A[47:12];
      fill_ppn  = 28'h000_0ABC;
      fill_huge = 1'b0;
      @(negedge clk);
      flush_all = 1'b0;
      fill_en   = 1'b0;
      lk_va     = VA_A;
      expect_now(1'b0, 28'h0, 1'b0, 9);                        // R9 fill dropped

      // R6: fill all slots, then evict in round-robin order
      for (int i = 0; i < 16; i++) begin
         fill(VA_P + 48'(i) * 48'h1000, 28'h100 + 28'(i), 1'b0);
      end
      look(VA_P, 1'b1, 28'h100, 1'b0, 5);                      // R5
      look(VA_P + 48'hF000, 1'b1, 28'h10F, 1'b0, 5);           // R5
      fill(VA_P + 48'h1_0000, 28'h200, 1'b0);
      look(VA_P, 1'b0, 28'h0, 1'b0, 6);                        // R6 slot 0 evicted
      look(VA_P + 48'h1_0000, 1'b1, 28'h200, 1'b0, 6);         // R6
      look(VA_P + 48'h1000, 1'b1, 28'h101, 1'b0, 6);           // R6
      fill(VA_P + 48'h1_1000, 28'h201, 1'b0);
      look(VA_P + 48'h1000, 1'b0, 28'h0, 1'b0, 6);             // R6 slot 1 evicted
      look(VA_P + 48'h2000, 1'b1, 28'h102, 1'b0, 6);           // R6

      // R5: freed slot is reused before the pointer victim
      inval(VA_P + 48'h5000);
      look(VA_P + 48'h5000, 1'b0, 28'h0, 1'b0, 8);             // R8
      fill(48'h0000_0200_0000, 28'h300, 1'b0);
      fill(48'h0000_0200_1000, 28'h301, 1'b0);
      look(48'h0000_0200_0000, 1'b1, 28'h300, 1'b0, 5);        // R5
      look(VA_P + 48'h2000, 1'b0, 28'h0, 1'b0, 6);             // R6 slot 2 evicted
      look(48'h0000_0200_1000, 1'b1, 28'h301, 1'b0, 6);        // R6
      look(VA_P + 48'h3000, 1'b1, 28'h103, 1'b0, 5);           // R5

      // R11: invalidate and fill of the same page together
      @(negedge clk);
      inv_en    = 1'b1;
      inv_vpn   = VA_P[47:12] + 36'h3;
      fill_en   = 1'b1;
      fill_vpn  = VA_P[47:12] + 36'h3;
      fill_ppn  = 28'h0AA_AAAA;
      fill_huge = 1'b0;
      @(negedge clk);
      inv_en  = 1'b0;
      fill_en = 1'b0;
      lk_va   = VA_P + 48'h3123;
      expect_now(1'b1, 28'h0AA_AAAA, 1'b0, 11);                // R11
      look(VA_P + 48'h4000, 1'b1, 28'h104, 1'b0, 11);          // R11 neighbour kept

      @(negedge clk);
      if (sb_q.size() != 0) begin
         mismatched++;
         $display("FAIL scoreboard: %0d items left, expected 0", sb_q.size());
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

endmodule